// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel NOR flash model. It runs on a system clock. It passes the bus write strobe through a synchronizer and treats each low-then-high pulse of write enable, taken while chip enable is low, as one bus write. The address of a bus write is captured when the strobe falls and the data when it rises. A sequence state machine looks for command sequences that open with a two-write unlock prefix. When a sequence completes, the block sends the embedded operation engine a one-clock request that carries the captured address and data.

The engine reports a two-bit status. The decoder uses it to decide which commands it accepts. The block also drives the read data mux. In array mode it passes array data through. In identifier mode it returns the maker code, the device code or the protect status of the addressed sector.

States of the sequence machine:
- `SQ_READ`: idle, reading the array or identifier codes.
- `SQ_UNL1`: the first unlock write has been seen.
- `SQ_UNL2`: the full prefix has been seen.
- `SQ_PGM_ARM`: the next write is the program target.
- `SQ_ERS_ARM`: erase setup has been seen.
- `SQ_ERS_UNL1` and `SQ_ERS_UNL2`: the second prefix of an erase is in progress.

Transitions:
- `SQ_READ` goes to `SQ_UNL1` on AAh at 555h.
- `SQ_UNL1` goes to `SQ_UNL2` on 55h at 2AAh.
- `SQ_UNL2` goes to `SQ_PGM_ARM` on A0h at 555h, goes to `SQ_ERS_ARM` on 80h at 555h, and goes back to `SQ_READ` on 90h at 555h with identifier mode set.
- `SQ_PGM_ARM` goes to `SQ_READ` on any write and issues the program request.
- `SQ_ERS_ARM` goes to `SQ_ERS_UNL1` on AAh at 555h.
- `SQ_ERS_UNL1` goes to `SQ_ERS_UNL2` on 55h at 2AAh.
- `SQ_ERS_UNL2` goes to `SQ_READ` and issues a chip erase request (10h at 555h) or a sector erase request (30h at any address).
- Every other write goes back to `SQ_READ` and clears identifier mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset no request output is high, and read data equals the array data input. Array mode is the default.
- R2: The four writes AAh@555h, 55h@2AAh, A0h@555h, then (A,D) give exactly one `req_prog` pulse. That pulse carries the full 17-bit A on `req_addr` and D on `req_data`. In the command writes only address bits 10:0 are compared, and bits 16:11 may take any value.
- R3: The two prefixes around 80h@555h, followed by 10h@555h, give one `req_chip_erase` pulse.
- R4: The two prefixes around 80h@555h, followed by 30h at address S, give one `req_sect_erase` pulse with `req_addr` equal to S.
- R5: After the prefix and 90h@555h the block is in identifier mode. In that mode, reads at low bits 00 return the maker code C2h and reads at low bits 01 return DEV_CODE. A read whose low address byte is 02h returns 01h when `protect_flag` is 1 and 00h when it is 0.
- R6: A write that breaks a sequence gives no request and puts the block back in array read mode.
- R7: A single F0h write, or the prefix followed by F0h, puts the block back in array read mode. F0h written as program data is programmed.
- R8: The engine status is encoded as 00 idle, 01 programming, 10 erasing and 11 suspended. While it is 01, every write is ignored, and the sequence state and the read mode are kept.
- R9: While the status is 10, only B0h (written at any address) is accepted, and it gives one `req_suspend` pulse. All other writes are ignored.
- R10: A single 30h write gives one `req_resume` pulse only while the status is 11. When the status is idle, the same write gives no pulse.
- R11: While the status is 11, program sequences are accepted, and completed chip or sector erase sequences issue no request.
- R12: A write-enable pulse while chip enable is high is ignored.
- R13: Each accepted command gives exactly one request, one clock wide, and at most one request output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low, asynchronous to clk |
| addr | input | 17 | Bus address |
| wdata | input | 8 | Bus write data |
| eng_state | input | 2 | Engine status: 00 idle, 01 programming, 10 erasing, 11 suspended |
| array_rdata | input | 8 | Data read from the array |
| protect_flag | input | 1 | Protect status of the addressed sector |
| req_prog | output | 1 | Program request pulse |
| req_chip_erase | output | 1 | Chip erase request pulse |
| req_sect_erase | output | 1 | Sector erase request pulse |
| req_suspend | output | 1 | Erase suspend request pulse |
| req_resume | output | 1 | Erase resume request pulse |
| req_addr | output | 17 | Address captured with the last request |
| req_data | output | 8 | Data captured with the last request |
| rdata | output | 8 | Read data mux output |

## Verification
The bench builds the block with the full 17-bit address, an 11-bit command compare and a two-stage synchronizer. This puts random upper address bits within reach, so they exercise both the don't-care path in command writes and the full capture on program and sector targets. DEV_CODE is overridden to 19h, which shows that the identifier read takes its code from the parameter and not from a fixed constant. Each engine status is driven directly, so the gating of accepted commands in every mode can be reached without modelling an engine.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'b00,
        ENG_PROG  = 2'b01,
        ENG_ERASE = 2'b10,
        ENG_SUSP  = 2'b11
    } eng_state_e;

    typedef enum logic [2:0] {
        SQ_READ,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PGM_ARM,
        SQ_ERS_ARM,
        SQ_ERS_UNL1,
        SQ_ERS_UNL2
    } seq_state_e;

    localparam logic [7:0] BYTE_UNLK_A  = 8'hAA;
    localparam logic [7:0] BYTE_UNLK_B  = 8'h55;
    localparam logic [7:0] BYTE_PGM     = 8'hA0;
    localparam logic [7:0] BYTE_ERS_SET = 8'h80;
    localparam logic [7:0] BYTE_CHIP    = 8'h10;
    localparam logic [7:0] BYTE_SECT    = 8'h30;
    localparam logic [7:0] BYTE_IDENT   = 8'h90;
    localparam logic [7:0] BYTE_RST     = 8'hF0;
    localparam logic [7:0] BYTE_SUSP    = 8'hB0;
    localparam logic [7:0] BYTE_RESUME  = 8'h30;

    localparam int unsigned PAT_A = 32'h555;
    localparam int unsigned PAT_B = 32'h2AA;

endpackage

// File: rtl/fcd_wr_capture.sv
module fcd_wr_capture #(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   we_d;
    logic                   armed;
    logic                   we_s;
    logic                   fall_q;
    logic                   rise_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= we_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], we_n};
            end
        end
    endgenerate

    assign we_s   = sync_q[SYNC_STAGES-1];
    assign fall_q = we_d & ~we_s & ~ce_n;
    assign rise_q = ~we_d & we_s & ~ce_n & armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_d    <= 1'b1;
            armed   <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            we_d   <= we_s;
            wr_stb <= rise_q;
            if (fall_q) begin
                wr_addr <= addr;
                armed   <= 1'b1;
            end
            if (rise_q) begin
                wr_data <= wdata;
                armed   <= 1'b0;
            end
        end
    end

    // R12
    stb_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !$past(ce_n));

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int CMP_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  eng_state_e        eng,
    output logic              req_prog,
    output logic              req_chip_erase,
    output logic              req_sect_erase,
    output logic              req_suspend,
    output logic              req_resume,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              ident_mode
);

    localparam logic [CMP_W-1:0] ADR_A = CMP_W'(PAT_A);
    localparam logic [CMP_W-1:0] ADR_B = CMP_W'(PAT_B);

    seq_state_e state, nxt_state;
    logic       nxt_ident;
    logic       p_prog, p_chip, p_sect, p_susp, p_res;
    logic       at_a, at_b;

    assign at_a = (wr_addr[CMP_W-1:0] == ADR_A);
    assign at_b = (wr_addr[CMP_W-1:0] == ADR_B);

    always_comb begin
        nxt_state = state;
        nxt_ident = ident_mode;
        p_prog = 1'b0;
        p_chip = 1'b0;
        p_sect = 1'b0;
        p_susp = 1'b0;
        p_res  = 1'b0;
        if (wr_stb) begin
            unique case (eng)
                ENG_PROG: begin
                end
                ENG_ERASE: begin
                    if (wr_data == BYTE_SUSP) p_susp = 1'b1;
                end
                ENG_IDLE, ENG_SUSP: begin
                    if (state != SQ_PGM_ARM && wr_data == BYTE_RST) begin
                        nxt_state = SQ_READ;
                        nxt_ident = 1'b0;
                    end else begin
                        nxt_state = SQ_READ;
                        unique case (state)
                            SQ_READ: begin
                                if (at_a && wr_data == BYTE_UNLK_A)
                                    nxt_state = SQ_UNL1;
                                else if (eng == ENG_SUSP && wr_data == BYTE_RESUME)
                                    p_res = 1'b1;
                                else
                                    nxt_ident = 1'b0;
                            end
                            SQ_UNL1: begin
                                if (at_b && wr_data == BYTE_UNLK_B) nxt_state = SQ_UNL2;
                                else                                nxt_ident = 1'b0;
                            end
                            SQ_UNL2: begin
                                if (at_a && wr_data == BYTE_PGM)
                                    nxt_state = SQ_PGM_ARM;
                                else if (at_a && wr_data == BYTE_ERS_SET)
                                    nxt_state = SQ_ERS_ARM;
                                else if (at_a && wr_data == BYTE_IDENT)
                                    nxt_ident = 1'b1;
                                else
                                    nxt_ident = 1'b0;
                            end
                            SQ_PGM_ARM: begin
                                p_prog    = 1'b1;
                                nxt_ident = 1'b0;
                            end
                            SQ_ERS_ARM: begin
                                if (at_a && wr_data == BYTE_UNLK_A) nxt_state = SQ_ERS_UNL1;
                                else                                nxt_ident = 1'b0;
                            end
                            SQ_ERS_UNL1: begin
                                if (at_b && wr_data == BYTE_UNLK_B) nxt_state = SQ_ERS_UNL2;
                                else                                nxt_ident = 1'b0;
                            end
                            SQ_ERS_UNL2: begin
                                nxt_ident = 1'b0;
                                if (eng == ENG_IDLE) begin
                                    if (at_a && wr_data == BYTE_CHIP) p_chip = 1'b1;
                                    else if (wr_data == BYTE_SECT)    p_sect = 1'b1;
                                end
                            end
                            default: nxt_ident = 1'b0;
                        endcase
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= SQ_READ;
            ident_mode <= 1'b0;
        end else begin
            state      <= nxt_state;
            ident_mode <= nxt_ident;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_prog       <= 1'b0;
            req_chip_erase <= 1'b0;
            req_sect_erase <= 1'b0;
            req_suspend    <= 1'b0;
            req_resume     <= 1'b0;
            req_addr       <= '0;
            req_data       <= '0;
        end else begin
            req_prog       <= p_prog;
            req_chip_erase <= p_chip;
            req_sect_erase <= p_sect;
            req_suspend    <= p_susp;
            req_resume     <= p_res;
            if (p_prog | p_chip | p_sect | p_susp | p_res) begin
                req_addr <= wr_addr;
                req_data <= wr_data;
            end
        end
    end

    // R13
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_prog, req_chip_erase, req_sect_erase, req_suspend, req_resume}));

    // R13
    prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_prog |=> !req_prog);

    // R8
    prog_busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && eng == ENG_PROG) |=>
        !(req_prog || req_chip_erase || req_sect_erase || req_suspend || req_resume));

    // R8
    prog_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng == ENG_PROG) |=> $stable(state) && $stable(ident_mode));

    // R9
    erase_only_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && eng == ENG_ERASE) |=>
        !(req_prog || req_chip_erase || req_sect_erase || req_resume));

    // R10
    resume_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_resume |-> $past(eng) == ENG_SUSP);

    // R11
    susp_no_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && eng == ENG_SUSP) |=> !(req_chip_erase || req_sect_erase));

    // R2
    arm_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_PGM_ARM && $past(state) != SQ_PGM_ARM) |-> $past(state) == SQ_UNL2);

endmodule

// File: rtl/fcd_rd_mux.sv
module fcd_rd_mux #(
    parameter int         DATA_W   = 8,
    parameter logic [7:0] MFR_CODE = 8'hC2,
    parameter logic [7:0] DEV_CODE = 8'h18
) (
    input  logic              ident_mode,
    input  logic [7:0]        rd_addr_lo,
    input  logic [DATA_W-1:0] array_rdata,
    input  logic              protect_flag,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        if (!ident_mode) begin
            rdata = array_rdata;
        end else if (rd_addr_lo[1:0] == 2'b00) begin
            rdata = DATA_W'(MFR_CODE);
        end else if (rd_addr_lo[1:0] == 2'b01) begin
            rdata = DATA_W'(DEV_CODE);
        end else if (rd_addr_lo == 8'h02) begin
            rdata = DATA_W'(protect_flag);
        end else begin
            rdata = '0;
        end
    end

    // R1
    always_comb begin
        if (!ident_mode) array_pass_chk: assert (rdata == array_rdata);
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int         ADDR_W      = 17,
    parameter int         DATA_W      = 8,
    parameter int         CMP_W       = 11,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] MFR_CODE    = 8'hC2,
    parameter logic [7:0] DEV_CODE    = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        eng_state,
    input  logic [DATA_W-1:0] array_rdata,
    input  logic              protect_flag,
    output logic              req_prog,
    output logic              req_chip_erase,
    output logic              req_sect_erase,
    output logic              req_suspend,
    output logic              req_resume,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [DATA_W-1:0] rdata
);

    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              ident_mode;
    eng_state_e        eng;

    assign eng = eng_state_e'(eng_state);

    fcd_wr_capture #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .wdata(wdata),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    fcd_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .eng(eng),
        .req_prog(req_prog), .req_chip_erase(req_chip_erase),
        .req_sect_erase(req_sect_erase), .req_suspend(req_suspend),
        .req_resume(req_resume), .req_addr(req_addr), .req_data(req_data),
        .ident_mode(ident_mode)
    );

    fcd_rd_mux #(
        .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
    ) u_mux (
        .ident_mode(ident_mode), .rd_addr_lo(addr[7:0]),
        .array_rdata(array_rdata), .protect_flag(protect_flag), .rdata(rdata)
    );

endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] TB_DEV = 8'h19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [1:0]  eng_state = 2'b00;
    logic [7:0]  array_rdata = 8'h5A;
    logic        protect_flag = 1'b0;
    logic        req_prog, req_chip_erase, req_sect_erase, req_suspend, req_resume;
    logic [16:0] req_addr;
    logic [7:0]  req_data;
    logic [7:0]  rdata;

    int checks = 0;
    int errors = 0;
    int n_prog = 0, n_chip = 0, n_sect = 0, n_susp = 0, n_res = 0;
    logic [16:0] last_addr = '0;
    logic [7:0]  last_data = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder #(.DEV_CODE(TB_DEV)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .wdata(wdata), .eng_state(eng_state), .array_rdata(array_rdata),
        .protect_flag(protect_flag), .req_prog(req_prog),
        .req_chip_erase(req_chip_erase), .req_sect_erase(req_sect_erase),
        .req_suspend(req_suspend), .req_resume(req_resume),
        .req_addr(req_addr), .req_data(req_data), .rdata(rdata)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (req_prog)       n_prog++;
            if (req_chip_erase) n_chip++;
            if (req_sect_erase) n_sect++;
            if (req_suspend)    n_susp++;
            if (req_resume)     n_res++;
            if (req_prog | req_chip_erase | req_sect_erase | req_suspend | req_resume) begin
                last_addr = req_addr;
                last_data = req_data;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input bit ident, input logic [16:0] a,
                                          input bit prot, input logic [7:0] arr);
        if (!ident)             return arr;
        if (a[1:0] == 2'b00)    return 8'hC2;
        if (a[1:0] == 2'b01)    return TB_DEV;
        if (a[7:0] == 8'h02)    return {7'b0, prot};
        return 8'h00;
    endfunction

    function automatic logic [16:0] hi_rand(input logic [10:0] lo);
        logic [5:0] up = 6'($urandom);
        return {up, lo};
    endfunction

    task automatic bus_wr(input logic [16:0] a, input logic [7:0] d, input bit ce_hi = 0);
        @(negedge clk);
        addr = a; wdata = d; ce_n = ce_hi; we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic unlock();
        bus_wr(hi_rand(11'h555), 8'hAA);
        bus_wr(hi_rand(11'h2AA), 8'h55);
    endtask

    task automatic do_prog(input logic [16:0] a, input logic [7:0] d);
        unlock(); bus_wr(hi_rand(11'h555), 8'hA0); bus_wr(a, d);
    endtask

    task automatic do_erase(input logic [16:0] a, input logic [7:0] d);
        unlock(); bus_wr(hi_rand(11'h555), 8'h80);
        unlock(); bus_wr(a, d);
    endtask

    task automatic enter_ident();
        unlock(); bus_wr(hi_rand(11'h555), 8'h90);
    endtask

    task automatic rd_chk(input logic [16:0] a, input bit ident, input string rq);
        logic [7:0] e;
        @(negedge clk);
        addr = a;
        #1;
        e = exp_rd(ident, a, protect_flag, array_rdata);
        chk(rdata == e, rq, rdata, e);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            report();
        end
    end

    initial begin
        int e_prog, e_chip, e_sect, e_susp, e_res;
        int seed_dummy;
        seed_dummy = $urandom(32'h1F2E);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(!(req_prog | req_chip_erase | req_sect_erase | req_suspend | req_resume),
            "R1 req idle", 0, 0);
        rd_chk(17'h00000, 0, "R1 array read");

        // R2 directed program with upper unlock bits random
        do_prog(17'h1_2345, 8'h3C);
        chk(n_prog == 1, "R2 prog count", n_prog, 1);
        chk(last_addr == 17'h1_2345, "R2 prog addr", last_addr, 17'h1_2345);
        chk(last_data == 8'h3C, "R2 prog data", last_data, 8'h3C);

        // random mix
        e_prog = n_prog; e_chip = n_chip; e_sect = n_sect;
        for (int it = 0; it < 16; it++) begin
            int op;
            logic [16:0] ra;
            logic [7:0]  rd;
            op = int'($urandom % 5);
            ra = 17'($urandom);
            rd = 8'($urandom);
            array_rdata = 8'($urandom);
            case (op)
                0: begin
                    do_prog(ra, rd); e_prog++;
                    chk(n_prog == e_prog, "R2 rand prog", n_prog, e_prog);
                    chk(last_addr == ra && last_data == rd, "R2 rand prog payload",
                        int'({last_addr, last_data}), int'({ra, rd}));
                end
                1: begin
                    do_erase(hi_rand(11'h555), 8'h10); e_chip++;
                    chk(n_chip == e_chip, "R3 chip erase", n_chip, e_chip);
                end
                2: begin
                    do_erase(ra, 8'h30); e_sect++;
                    chk(n_sect == e_sect, "R4 sector erase", n_sect, e_sect);
                    chk(last_addr == ra, "R4 sector addr", last_addr, ra);
                end
                3: begin
                    protect_flag = 1'($urandom);
                    enter_ident();
                    rd_chk({ra[16:2], 2'b00}, 1, "R5 maker code");
                    rd_chk({ra[16:2], 2'b01}, 1, "R5 device code");
                    rd_chk({ra[16:8], 8'h02}, 1, "R5 protect status");
                    bus_wr(ra, 8'hF0);
                    rd_chk(ra, 0, "R7 F0 exit");
                end
                default: begin
                    enter_ident();
                    unlock();
                    bus_wr(hi_rand(11'h555), 8'h11);
                    chk(n_prog == e_prog && n_chip == e_chip && n_sect == e_sect,
                        "R6 no request", n_prog + n_chip + n_sect, e_prog + e_chip + e_sect);
                    rd_chk(17'h00000, 0, "R6 array after break");
                end
            endcase
        end

        // R6 wrong address in prefix
        e_prog = n_prog;
        bus_wr(hi_rand(11'h555), 8'hAA);
        bus_wr(hi_rand(11'h2AB), 8'h55);
        bus_wr(hi_rand(11'h555), 8'hA0);
        bus_wr(17'h00010, 8'h77);
        chk(n_prog == e_prog, "R6 bad address", n_prog, e_prog);

        // R7 prefix + F0, and F0 as program data
        enter_ident();
        unlock(); bus_wr(hi_rand(11'h555), 8'hF0);
        rd_chk(17'h00000, 0, "R7 prefix F0 exit");
        e_prog = n_prog + 1;
        do_prog(17'h0_0F0F, 8'hF0);
        chk(n_prog == e_prog && last_data == 8'hF0, "R7 F0 programmed", last_data, 8'hF0);

        // R8 engine programming: writes ignored
        enter_ident();
        eng_state = 2'b01;
        e_prog = n_prog; e_susp = n_susp;
        bus_wr(17'h00000, 8'hF0);
        do_prog(17'h00123, 8'h45);
        bus_wr(17'h00000, 8'hB0);
        chk(n_prog == e_prog && n_susp == e_susp, "R8 no request", n_prog, e_prog);
        rd_chk(17'h00000, 1, "R8 ident kept");
        eng_state = 2'b00;
        bus_wr(17'h00000, 8'hF0);

        // R9 engine erasing: only suspend
        eng_state = 2'b10;
        e_prog = n_prog; e_susp = n_susp + 1;
        do_prog(17'h00456, 8'h12);
        bus_wr(17'h00000, 8'h30);
        chk(n_prog == e_prog && n_res == 0, "R9 others ignored", n_prog, e_prog);
        bus_wr(17'h1_7777, 8'hB0);
        chk(n_susp == e_susp, "R9 suspend", n_susp, e_susp);
        chk(last_addr == 17'h1_7777, "R13 suspend payload", last_addr, 17'h1_7777);

        // R10 resume only when suspended
        eng_state = 2'b00;
        e_res = n_res;
        bus_wr(17'h00000, 8'h30);
        chk(n_res == e_res, "R10 resume idle", n_res, e_res);
        eng_state = 2'b11;
        bus_wr(17'h00000, 8'h30);
        e_res++;
        chk(n_res == e_res, "R10 resume suspended", n_res, e_res);

        // R11 suspended: program accepted, erase dropped
        e_prog = n_prog + 1; e_chip = n_chip; e_sect = n_sect;
        do_prog(17'h0_4444, 8'h99);
        chk(n_prog == e_prog, "R11 prog while suspended", n_prog, e_prog);
        do_erase(hi_rand(11'h555), 8'h10);
        do_erase(17'h1_0000, 8'h30);
        chk(n_chip == e_chip && n_sect == e_sect, "R11 erase dropped",
            n_chip + n_sect, e_chip + e_sect);
        eng_state = 2'b00;

        // R12 chip enable high
        enter_ident();
        bus_wr(17'h00000, 8'h11, 1);
        rd_chk(17'h00001, 1, "R12 ident kept");
        bus_wr(17'h00000, 8'hF0);
        e_prog = n_prog;
        unlock(); bus_wr(hi_rand(11'h555), 8'hA0);
        bus_wr(17'h00200, 8'h66, 1);
        chk(n_prog == e_prog, "R12 final write ignored", n_prog, e_prog);
        bus_wr(17'h00200, 8'h66);
        chk(n_prog == e_prog + 1, "R13 single pulse", n_prog, e_prog + 1);

        done = 1;
        report();
    end

endmodule